// File: doc/BRIEF.md
# Dependence-Based Instruction Steering Unit

This block sits after register renaming and decides, one instruction per cycle, which instruction buffer the instruction enters. The buffers are small in-order FIFOs spread over a set of execution units grouped into clusters. The default is two clusters of four units with four buffers per unit, so there are 32 buffers. The steering goal is to keep dependent instructions in straight chains. A consumer is placed directly behind the instruction that produces its operand whenever that position is still free. When it is not, the instruction falls back to an unused buffer close to its producer, and the unit stalls if no such buffer exists.

Three pieces of state drive the decision. A producer table, indexed by architectural register, records the buffer holding the most recent writer of each register. A per-register chained flag records whether that writer already has a consumer queued behind it. A per-buffer vacancy vector records which buffers are unused. When an instruction is placed, the unit reports the chosen buffer and the execution unit that owns it. In the same cycle it raises a notification bit toward every execution unit holding one of the instruction's outstanding producers, so each producer learns where to send its result.

Buffer numbering is fixed: buffer `b` belongs to execution unit `b / 4` and to cluster `b / 16`. An external drain signal returns a buffer to the vacant pool.

Top module: `steer_unit`

## Requirements
- R1: After reset every buffer is vacant, and the first instruction with no outstanding source is placed in buffer 0 (unit 0) with the stall output low.
- R2: An instruction with no outstanding source goes to the lowest-numbered vacant buffer across all clusters, and the reported unit is that buffer number divided by 4.
- R3: With exactly one outstanding source whose producer has no chained consumer yet, the instruction is placed in the producer's buffer.
- R4: With exactly one outstanding source whose producer is already chained, the instruction goes to the lowest vacant buffer in the producer's cluster (cluster = buffer / 16), even when a lower vacant buffer exists in another cluster.
- R5: With two outstanding sources, the instruction chains behind the first source's producer if that producer is unchained. Otherwise it chains behind the second source's producer if that one is unchained.
- R6: With two outstanding sources whose producers are both chained, the instruction goes to the lowest vacant buffer in the union of the two producers' clusters.
- R7: When no eligible position exists, the stall output is high, nothing is placed and the steering state is left unchanged.
- R8: Once a consumer has been chained behind a producer, a later consumer of the same register cannot chain behind it.
- R9: A placed instruction that writes a register becomes that register's producer, in the chosen buffer, with no chained consumer.
- R10: A drain request returns a buffer to the vacant pool. When a drain and a vacant-buffer placement name the same buffer in one cycle, the buffer ends up occupied.
- R11: On a placement, the notification vector (bit `e` for unit `e`) has a bit set for the unit of each outstanding source's producer and no other bit. Without a placement it is all zeros.
- R12: With the valid input low, no placement is made, stall stays low and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| src0_reg | input | 5 | First source register |
| src0_pend | input | 1 | First source is still being produced |
| src1_reg | input | 5 | Second source register |
| src1_pend | input | 1 | Second source is still being produced |
| dst_reg | input | 5 | Destination register |
| dst_valid | input | 1 | Instruction writes dst_reg |
| drain_valid | input | 1 | A buffer has emptied |
| drain_buf | input | 5 | Buffer that emptied |
| steer_fire | output | 1 | Instruction placed this cycle |
| steer_buf | output | 5 | Chosen buffer |
| steer_eu | output | 3 | Execution unit owning the chosen buffer |
| steer_stall | output | 1 | Instruction cannot be placed this cycle |
| notify_mask | output | 8 | Producer units told of the chosen unit |

## Verification
On every cycle, the assertions check four properties. Stall and placement never coincide. An idle cycle is quiet. A fallback placement lands in a buffer that was vacant and stays inside the producer's cluster. A buffer taken for an independent instruction is occupied on the next cycle, even when a drain hits it at the same moment. Some behaviours need a history to set up, and only the directed scenarios can show them. These are the cluster-affine choice over a lower buffer elsewhere, the first-source priority when both producers are free, the refusal of a second chain behind the same producer, and the new producer's entry taking effect for the next consumer. The same applies to stalls that depend on one cluster being full while the other has room.

// File: rtl/steer_pkg.sv
// Shared types for the steering unit.
// Assumes nothing beyond the parameter rules of the modules that import it.
package steer_pkg;

    // Which branch of the decision tree produced the placement.
    typedef enum logic [1:0] {
        PICK_NONE   = 2'd0,
        PICK_CHAIN0 = 2'd1,
        PICK_CHAIN1 = 2'd2,
        PICK_VACANT = 2'd3
    } pick_kind_e;

endpackage

// File: rtl/steer_prod_table.sv
// Last-producer table with a per-register chained flag.
// Two read ports serve the two sources. A chain mark and a producer
// write may arrive in the same cycle. When both name one register, the
// write wins, because the instruction becomes the new producer.
// Assumes: after reset every register points at buffer 0 and is marked
// chained, so a stale source never chains onto an unknown producer.
module steer_prod_table #(
    parameter int NUM_REGS = 32,
    parameter int BUF_W    = 5,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] rd0_reg,
    input  logic [REG_W-1:0] rd1_reg,
    output logic [BUF_W-1:0] rd0_buf,
    output logic [BUF_W-1:0] rd1_buf,
    output logic             rd0_full,
    output logic             rd1_full,
    input  logic             mark_en,
    input  logic [REG_W-1:0] mark_reg,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_reg,
    input  logic [BUF_W-1:0] wr_buf
);

    logic [BUF_W-1:0]    prod_q [NUM_REGS];
    logic [NUM_REGS-1:0] full_q;

    // Read ports: combinational lookup for both sources.
    always_comb begin
        rd0_buf  = prod_q[rd0_reg];
        rd1_buf  = prod_q[rd1_reg];
        rd0_full = full_q[rd0_reg];
        rd1_full = full_q[rd1_reg];
    end

    // Table update: apply the chain mark first, then the producer write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                prod_q[r] <= '0;
            end
            full_q <= '1;
        end else begin
            if (mark_en) begin
                full_q[mark_reg] <= 1'b1;
            end
            if (wr_en) begin
                prod_q[wr_reg] <= wr_buf;
                full_q[wr_reg] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/steer_vacancy.sv
// Vacancy vector over all buffers, plus a lowest-index picker limited to
// the clusters enabled by the mask.
// Assumes buffers are numbered cluster-major, BUFS_PER_CL per cluster.
// When a drain and an allocation name one buffer in the same cycle, the
// allocation wins.
module steer_vacancy #(
    parameter int NUM_CL      = 2,
    parameter int BUFS_PER_CL = 16,
    localparam int NUM_BUFS   = NUM_CL * BUFS_PER_CL,
    localparam int BUF_W      = $clog2(NUM_BUFS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_en,
    input  logic [BUF_W-1:0]    alloc_buf,
    input  logic                free_en,
    input  logic [BUF_W-1:0]    free_buf,
    input  logic [NUM_CL-1:0]   cl_mask,
    output logic                pick_found,
    output logic [BUF_W-1:0]    pick_buf,
    output logic [NUM_BUFS-1:0] vacant_o
);

    logic [NUM_BUFS-1:0] vacant_q;
    logic [NUM_BUFS-1:0] eligible;

    // Eligibility: a buffer qualifies if vacant and its cluster is enabled.
    for (genvar b = 0; b < NUM_BUFS; b++) begin : g_elig
        assign eligible[b] = vacant_q[b] & cl_mask[b / BUFS_PER_CL];
    end

    // Priority encoder: the lowest eligible index wins.
    always_comb begin
        pick_found = 1'b0;
        pick_buf   = '0;
        for (int b = NUM_BUFS - 1; b >= 0; b--) begin
            if (eligible[b]) begin
                pick_found = 1'b1;
                pick_buf   = BUF_W'(b);
            end
        end
    end

    // Vacancy update: the drain frees a buffer, the allocation then overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vacant_q <= '1;
        end else begin
            if (free_en) begin
                vacant_q[free_buf] <= 1'b1;
            end
            if (alloc_en) begin
                vacant_q[alloc_buf] <= 1'b0;
            end
        end
    end

    assign vacant_o = vacant_q;

endmodule

// File: rtl/steer_decide.sv
// Cluster-affine decision tree.
// It produces the cluster mask for the vacancy picker, then chooses
// between chaining behind a producer and taking a vacant buffer.
// Assumes an outstanding source's producer still holds its buffer.
module steer_decide
    import steer_pkg::*;
#(
    parameter int NUM_CL      = 2,
    parameter int BUFS_PER_CL = 16,
    localparam int BUF_W      = $clog2(NUM_CL * BUFS_PER_CL),
    localparam int CL_SHIFT   = $clog2(BUFS_PER_CL)
) (
    input  logic              src0_pend,
    input  logic              src1_pend,
    input  logic [BUF_W-1:0]  prod0_buf,
    input  logic [BUF_W-1:0]  prod1_buf,
    input  logic              prod0_full,
    input  logic              prod1_full,
    input  logic              pick_found,
    input  logic [BUF_W-1:0]  pick_buf,
    output logic [NUM_CL-1:0] cl_mask,
    output pick_kind_e        kind,
    output logic [BUF_W-1:0]  target_buf
);

    logic [BUF_W-1:0] cl0_full_w;
    logic [BUF_W-1:0] cl1_full_w;

    assign cl0_full_w = prod0_buf >> CL_SHIFT;
    assign cl1_full_w = prod1_buf >> CL_SHIFT;

    // Cluster mask: everything when independent, else the producers' clusters.
    for (genvar c = 0; c < NUM_CL; c++) begin : g_mask
        assign cl_mask[c] = (!src0_pend && !src1_pend)
                          || (src0_pend && (cl0_full_w == BUF_W'(c)))
                          || (src1_pend && (cl1_full_w == BUF_W'(c)));
    end

    // Decision: chain behind source 0, then source 1, then fall back to a vacancy.
    always_comb begin
        kind       = PICK_NONE;
        target_buf = '0;
        if (src0_pend && !prod0_full) begin
            kind       = PICK_CHAIN0;
            target_buf = prod0_buf;
        end else if (src1_pend && !prod1_full) begin
            kind       = PICK_CHAIN1;
            target_buf = prod1_buf;
        end else if (pick_found) begin
            kind       = PICK_VACANT;
            target_buf = pick_buf;
        end
    end

endmodule

// File: rtl/steer_unit.sv
// Top of the steering unit. It places one renamed instruction per cycle
// into a buffer and notifies the producers' units of the chosen unit.
// Assumes buffer IDs are unit-major (BUFS_PER_EU per unit) and units are
// cluster-major (EUS_PER_CL per cluster). All counts are powers of two.
module steer_unit
    import steer_pkg::*;
#(
    parameter int NUM_REGS    = 32,
    parameter int NUM_CL      = 2,
    parameter int EUS_PER_CL  = 4,
    parameter int BUFS_PER_EU = 4,
    localparam int NUM_EUS     = NUM_CL * EUS_PER_CL,
    localparam int BUFS_PER_CL = EUS_PER_CL * BUFS_PER_EU,
    localparam int NUM_BUFS    = NUM_CL * BUFS_PER_CL,
    localparam int REG_W       = $clog2(NUM_REGS),
    localparam int BUF_W       = $clog2(NUM_BUFS),
    localparam int EU_W        = $clog2(NUM_EUS),
    localparam int EU_SHIFT    = $clog2(BUFS_PER_EU)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [REG_W-1:0]   src0_reg,
    input  logic               src0_pend,
    input  logic [REG_W-1:0]   src1_reg,
    input  logic               src1_pend,
    input  logic [REG_W-1:0]   dst_reg,
    input  logic               dst_valid,
    input  logic               drain_valid,
    input  logic [BUF_W-1:0]   drain_buf,
    output logic               steer_fire,
    output logic [BUF_W-1:0]   steer_buf,
    output logic [EU_W-1:0]    steer_eu,
    output logic               steer_stall,
    output logic [NUM_EUS-1:0] notify_mask
);

    logic [BUF_W-1:0]    prod0_buf;
    logic [BUF_W-1:0]    prod1_buf;
    logic                prod0_full;
    logic                prod1_full;
    logic [NUM_CL-1:0]   cl_mask;
    logic                pick_found;
    logic [BUF_W-1:0]    pick_buf;
    logic [NUM_BUFS-1:0] vacant_vec;
    pick_kind_e          kind;
    logic [BUF_W-1:0]    target_buf;
    logic                mark_en;
    logic [REG_W-1:0]    mark_reg;
    logic [BUF_W-1:0]    eu0_w;
    logic [BUF_W-1:0]    eu1_w;
    logic [BUF_W-1:0]    eu_sel_w;

    steer_prod_table #(
        .NUM_REGS (NUM_REGS),
        .BUF_W    (BUF_W)
    ) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd0_reg  (src0_reg),
        .rd1_reg  (src1_reg),
        .rd0_buf  (prod0_buf),
        .rd1_buf  (prod1_buf),
        .rd0_full (prod0_full),
        .rd1_full (prod1_full),
        .mark_en  (mark_en),
        .mark_reg (mark_reg),
        .wr_en    (steer_fire && dst_valid),
        .wr_reg   (dst_reg),
        .wr_buf   (target_buf)
    );

    steer_vacancy #(
        .NUM_CL      (NUM_CL),
        .BUFS_PER_CL (BUFS_PER_CL)
    ) vac_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (steer_fire && (kind == PICK_VACANT)),
        .alloc_buf  (target_buf),
        .free_en    (drain_valid),
        .free_buf   (drain_buf),
        .cl_mask    (cl_mask),
        .pick_found (pick_found),
        .pick_buf   (pick_buf),
        .vacant_o   (vacant_vec)
    );

    steer_decide #(
        .NUM_CL      (NUM_CL),
        .BUFS_PER_CL (BUFS_PER_CL)
    ) dec_i (
        .src0_pend  (src0_pend),
        .src1_pend  (src1_pend),
        .prod0_buf  (prod0_buf),
        .prod1_buf  (prod1_buf),
        .prod0_full (prod0_full),
        .prod1_full (prod1_full),
        .pick_found (pick_found),
        .pick_buf   (pick_buf),
        .cl_mask    (cl_mask),
        .kind       (kind),
        .target_buf (target_buf)
    );

    // Handshake: place when a choice exists, otherwise stall a valid instruction.
    always_comb begin
        steer_fire  = in_valid && (kind != PICK_NONE);
        steer_stall = in_valid && (kind == PICK_NONE);
        steer_buf   = target_buf;
        mark_en     = steer_fire && ((kind == PICK_CHAIN0) || (kind == PICK_CHAIN1));
        mark_reg    = (kind == PICK_CHAIN1) ? src1_reg : src0_reg;
    end

    assign eu0_w    = prod0_buf >> EU_SHIFT;
    assign eu1_w    = prod1_buf >> EU_SHIFT;
    assign eu_sel_w = target_buf >> EU_SHIFT;
    assign steer_eu = eu_sel_w[EU_W-1:0];

    // Producer notification: one bit per unit that holds an outstanding producer.
    for (genvar e = 0; e < NUM_EUS; e++) begin : g_notify
        assign notify_mask[e] = steer_fire
                              && ((src0_pend && (eu0_w == BUF_W'(e)))
                               || (src1_pend && (eu1_w == BUF_W'(e))));
    end

endmodule

// File: rtl/steer_unit_chk.sv
// Checker for the steering unit, bound into every instance of the top.
// It observes ports plus the producer lookups and the vacancy vector.
module steer_unit_chk #(
    parameter int NUM_BUFS    = 32,
    parameter int NUM_EUS     = 8,
    parameter int BUFS_PER_CL = 16,
    localparam int BUF_W      = $clog2(NUM_BUFS),
    localparam int CL_SHIFT   = $clog2(BUFS_PER_CL)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                src0_pend,
    input logic                src1_pend,
    input logic [BUF_W-1:0]    prod0_buf,
    input logic [BUF_W-1:0]    prod1_buf,
    input logic [NUM_BUFS-1:0] vacant_vec,
    input logic                steer_fire,
    input logic [BUF_W-1:0]    steer_buf,
    input logic                steer_stall,
    input logic [NUM_EUS-1:0]  notify_mask
);

    // R7: a stalled instruction is never also placed.
    p_stall_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        steer_stall |-> !steer_fire);

    // R12: an idle cycle neither places nor stalls.
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!steer_fire && !steer_stall));

    // R11: no notification without a placement.
    p_notify_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !steer_fire |-> (notify_mask == '0));

    // R4: a single-source fallback stays in the producer's cluster.
    p_fallback_cluster_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_fire && src0_pend && !src1_pend && (steer_buf != prod0_buf))
        |-> ((steer_buf >> CL_SHIFT) == (prod0_buf >> CL_SHIFT)));

    // R2: a placement outside every producer's buffer lands in a vacant buffer.
    p_target_vacant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_fire && (steer_buf != prod0_buf) && (steer_buf != prod1_buf))
        |-> vacant_vec[steer_buf]);

    // R10: an independent placement leaves its buffer occupied, even under a drain.
    p_placed_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_fire && !src0_pend && !src1_pend)
        |=> !vacant_vec[$past(steer_buf)]);

endmodule

bind steer_unit steer_unit_chk #(
    .NUM_BUFS    (NUM_BUFS),
    .NUM_EUS     (NUM_EUS),
    .BUFS_PER_CL (BUFS_PER_CL)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .src0_pend   (src0_pend),
    .src1_pend   (src1_pend),
    .prod0_buf   (prod0_buf),
    .prod1_buf   (prod1_buf),
    .vacant_vec  (vacant_vec),
    .steer_fire  (steer_fire),
    .steer_buf   (steer_buf),
    .steer_stall (steer_stall),
    .notify_mask (notify_mask)
);

// File: tb/steer_unit_tb_top.sv
// Directed bench for the steering unit. One task per scenario.
// Inputs change on the falling edge. Outputs are combinational from the
// inputs and state, so they are sampled 1 ns after the inputs change.
module steer_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [4:0] src0_reg, src1_reg, dst_reg, drain_buf;
    logic       src0_pend, src1_pend, dst_valid, drain_valid;
    logic       steer_fire, steer_stall;
    logic [4:0] steer_buf;
    logic [2:0] steer_eu;
    logic [7:0] notify_mask;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    steer_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .src0_reg    (src0_reg),
        .src0_pend   (src0_pend),
        .src1_reg    (src1_reg),
        .src1_pend   (src1_pend),
        .dst_reg     (dst_reg),
        .dst_valid   (dst_valid),
        .drain_valid (drain_valid),
        .drain_buf   (drain_buf),
        .steer_fire  (steer_fire),
        .steer_buf   (steer_buf),
        .steer_eu    (steer_eu),
        .steer_stall (steer_stall),
        .notify_mask (notify_mask)
    );

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 0; src0_reg = 0; src0_pend = 0; src1_reg = 0; src1_pend = 0;
        dst_reg = 0; dst_valid = 0; drain_valid = 0; drain_buf = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Offer one cycle of stimulus and compare all outputs against expectations.
    task automatic step(input string req, input logic v,
                        input logic [4:0] s0, input logic p0,
                        input logic [4:0] s1, input logic p1,
                        input logic [4:0] d, input logic dv,
                        input logic drv, input logic [4:0] drb,
                        input logic e_fire, input logic [4:0] e_buf,
                        input logic e_stall, input logic [7:0] e_notify);
        logic [2:0] e_eu;
        @(negedge clk);
        in_valid = v; src0_reg = s0; src0_pend = p0; src1_reg = s1; src1_pend = p1;
        dst_reg = d; dst_valid = dv; drain_valid = drv; drain_buf = drb;
        #1;
        e_eu = e_buf[4:2];
        checks++;
        if (steer_fire !== e_fire || steer_stall !== e_stall || notify_mask !== e_notify
            || (e_fire && (steer_buf !== e_buf || steer_eu !== e_eu))) begin
            errors++;
            $display("FAIL %s: fire=%0b buf=%0d eu=%0d stall=%0b notify=%h expected fire=%0b buf=%0d eu=%0d stall=%0b notify=%h",
                     req, steer_fire, steer_buf, steer_eu, steer_stall, notify_mask,
                     e_fire, e_buf, e_eu, e_stall, e_notify);
        end
    endtask

    task automatic indep(input string req, input logic [4:0] d, input logic [4:0] e_buf);
        step(req, 1, 0, 0, 0, 0, d, 1, 0, 0, 1, e_buf, 0, 8'h00);
    endtask

    task automatic idle(input string req, input logic drv, input logic [4:0] drb);
        step(req, 0, 0, 0, 0, 0, 0, 0, drv, drb, 0, 0, 0, 8'h00);
    endtask

    // R1 R2 R12: reset state and idle cycles.
    task automatic t_reset_idle();
        do_reset();
        step("R12 idle with data", 0, 3, 1, 4, 1, 5, 1, 0, 0, 0, 0, 0, 8'h00);
        indep("R1 first placement", 5'd1, 5'd0);
        indep("R2 next lowest", 5'd2, 5'd1);
        indep("R2 next lowest", 5'd3, 5'd2);
    endtask

    // R3 R8 R9 R11: chaining, second consumer refused, new producer used.
    task automatic t_chain();
        do_reset();
        indep("R2 producer", 5'd1, 5'd0);
        step("R3 chain behind producer", 1, 5'd1, 1, 0, 0, 5'd2, 1, 0, 0, 1, 5'd0, 0, 8'h01);
        step("R8 second consumer falls back", 1, 5'd1, 1, 0, 0, 5'd3, 1, 0, 0, 1, 5'd1, 0, 8'h01);
        step("R9 consumer of new producer", 1, 5'd2, 1, 0, 0, 5'd4, 1, 0, 0, 1, 5'd0, 0, 8'h01);
    endtask

    // R4 R10: cluster-affine fallback and drain reuse.
    task automatic t_cluster();
        do_reset();
        for (int i = 0; i < 16; i++) indep("R2 fill cluster 0", 5'(i), 5'(i));
        indep("R2 spill to cluster 1", 5'd20, 5'd16);
        idle("R10 drain buffer 3", 1, 5'd3);
        step("R3 chain in cluster 1", 1, 5'd20, 1, 0, 0, 0, 0, 0, 0, 1, 5'd16, 0, 8'h10);
        step("R4 stay in producer cluster", 1, 5'd20, 1, 0, 0, 0, 0, 0, 0, 1, 5'd17, 0, 8'h10);
        indep("R10 drained buffer reused", 5'd21, 5'd3);
    endtask

    // R5 R6: two outstanding sources.
    task automatic t_two_src();
        do_reset();
        indep("R2 producer A", 5'd1, 5'd0);
        indep("R2 producer B", 5'd2, 5'd1);
        step("R5 first source wins", 1, 5'd1, 1, 5'd2, 1, 5'd3, 1, 0, 0, 1, 5'd0, 0, 8'h01);
        step("R5 second source used", 1, 5'd1, 1, 5'd2, 1, 5'd4, 1, 0, 0, 1, 5'd1, 0, 8'h01);
        step("R6 both chained fallback", 1, 5'd1, 1, 5'd2, 1, 5'd5, 1, 0, 0, 1, 5'd2, 0, 8'h01);
    endtask

    // R6 R7 R11: stalls restricted by cluster, union of clusters.
    task automatic t_full_cluster();
        do_reset();
        for (int i = 0; i < 16; i++) indep("R2 fill cluster 0", 5'(i), 5'(i));
        indep("R2 producer in cluster 1", 5'd16, 5'd16);
        step("R3 chain r16", 1, 5'd16, 1, 0, 0, 0, 0, 0, 0, 1, 5'd16, 0, 8'h10);
        step("R3 chain r0", 1, 5'd0, 1, 0, 0, 0, 0, 0, 0, 1, 5'd0, 0, 8'h01);
        step("R3 chain r1", 1, 5'd1, 1, 0, 0, 0, 0, 0, 0, 1, 5'd1, 0, 8'h01);
        step("R7 stall both in full cluster", 1, 5'd0, 1, 5'd1, 1, 5'd9, 1, 0, 0, 0, 0, 1, 8'h00);
        step("R6 union of clusters", 1, 5'd0, 1, 5'd16, 1, 0, 0, 0, 0, 1, 5'd17, 0, 8'h11);
        step("R7 stall one source", 1, 5'd0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h00);
        idle("R10 drain buffer 5", 1, 5'd5);
        step("R10 drained buffer in cluster", 1, 5'd0, 1, 0, 0, 0, 0, 0, 0, 1, 5'd5, 0, 8'h01);
    endtask

    // R10: placement and drain on the same buffer in one cycle.
    task automatic t_collide();
        do_reset();
        step("R10 place with drain", 1, 0, 0, 0, 0, 5'd1, 1, 1, 5'd0, 1, 5'd0, 0, 8'h00);
        indep("R10 placement won", 5'd2, 5'd1);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_idle();
        t_chain();
        t_cluster();
        t_two_src();
        t_full_cluster();
        t_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule